// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

The block turns a stream of instruction bytes into decoded instruction records for a small 32-bit teaching instruction set. Bytes arrive one per valid/ready handshake. The parser reads the leading byte of an instruction and takes the class from its high nibble. The class decides whether a register byte follows, whether a multi-byte constant follows, or whether the instruction ends at once. When the last byte has been taken, the block presents a single record. The record holds the class, the function code, both register specifiers, the constant, the byte count, an invalid flag and a halt flag.

The leading byte of each instruction fixes the whole layout of that instruction. Once the parser is aligned at an instruction start, the stream therefore splits into instructions in only one way. Constant bytes are never read as opcodes, even when their values look like one. While a finished record waits for its consumer, the input side is closed. A synchronous reset discards any partial instruction and makes the parser wait for a new leading byte.

Top module: `ibyte_decoder`

## Requirements
- R1: `out_len` equals the instruction's byte count. Classes 0x0 (halt), 0x1 (nop) and 0x9 (return) are 1 byte. Classes 0x2 (register move), 0x6 (ALU), 0xA (push) and 0xB (pop) are 2 bytes. Classes 0x7 (jump) and 0x8 (call) are 5 bytes. Classes 0x3, 0x4 and 0x5 (immediate, store and load moves) are 6 bytes.
- R2: `out_class` is bits 7:4 of the leading byte and `out_func` is bits 3:0 of the leading byte.
- R3: For classes 0x2-0x6, 0xA and 0xB, the second byte is the register byte: `out_ra` is its bits 7:4 and `out_rb` is its bits 3:0. For every other class, both register outputs read 0xF, the no-register code.
- R4: For classes 0x3, 0x4, 0x5, 0x7 and 0x8, the last four bytes form `out_const`, least-significant byte first. For every other class, `out_const` is zero.
- R5: A class code above 0xB sets `out_invalid`, gives length 1, and ends the instruction, so the next byte is treated as a leading byte.
- R6: `out_halt` is 1 exactly when the class is 0x0.
- R7: `in_ready` is low while `out_valid` is high. Bytes offered in that time are not consumed. The record holds steady while `out_valid` is high and `out_ready` is low. Cycles with `in_valid` low advance nothing.
- R8: With `rst` high at a clock edge, `out_valid` is low and `in_ready` is high after that edge. Any partly received instruction is discarded.
- R9: Constant bytes are never decoded as leading bytes. Instructions sent back to back, including constants whose bytes match opcode values, split at the correct boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input byte is offered |
| in_ready | output | 1 | The parser can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | A decoded record is present |
| out_ready | input | 1 | The consumer takes the record |
| out_class | output | 4 | Instruction class |
| out_func | output | 4 | Function code |
| out_ra | output | 4 | First register specifier, 0xF when there is none |
| out_rb | output | 4 | Second register specifier, 0xF when there is none |
| out_const | output | CONST_BYTES*8 (32) | Assembled constant, zero when there is none |
| out_len | output | LEN_W (3) | Instruction length in bytes |
| out_invalid | output | 1 | Unknown class |
| out_halt | output | 1 | Halt instruction |

## Verification
The bench sends every defined class. A decoder with a wrong class table would then run past an instruction boundary or stop short of one, and every later record would come out shifted. It places opcode-like bytes inside a jump target, which catches a parser that wrongly resynchronises on constant bytes. It offers a byte while a record is stalled, which exposes a design that accepts input while its output is full. It also resets in the middle of an instruction, which shows whether stale partial state leaks into the next record. Undefined classes followed by a nop check that an invalid leading byte does not swallow the byte after it.

// File: rtl/idec_pkg.sv
package idec_pkg;

   typedef enum logic [1:0] {
      ST_HEAD  = 2'd0,
      ST_REGS  = 2'd1,
      ST_CONST = 2'd2,
      ST_EMIT  = 2'd3
   } idec_state_e;

   localparam logic [3:0] NO_REG    = 4'hF;
   localparam logic [3:0] CLS_HALT  = 4'h0;
   localparam logic [3:0] CLS_NOP   = 4'h1;
   localparam logic [3:0] CLS_RRMOV = 4'h2;
   localparam logic [3:0] CLS_IRMOV = 4'h3;
   localparam logic [3:0] CLS_RMMOV = 4'h4;
   localparam logic [3:0] CLS_MRMOV = 4'h5;
   localparam logic [3:0] CLS_ALU   = 4'h6;
   localparam logic [3:0] CLS_JUMP  = 4'h7;
   localparam logic [3:0] CLS_CALL  = 4'h8;
   localparam logic [3:0] CLS_RET   = 4'h9;
   localparam logic [3:0] CLS_PUSH  = 4'hA;
   localparam logic [3:0] CLS_POP   = 4'hB;
   localparam logic [3:0] CLS_LAST  = CLS_POP;

   typedef struct packed {
      logic has_reg;
      logic has_const;
      logic bad;
      logic halt;
   } idec_shape_t;

endpackage

// File: rtl/idec_class_table.sv
module idec_class_table
   import idec_pkg::*;
(
   input  logic [3:0]  cls,
   output idec_shape_t shape
);

   always_comb begin
      shape = '0;
      unique case (cls)
         CLS_HALT:  shape.halt = 1'b1;
         CLS_NOP,
         CLS_RET:   shape = '0;
         CLS_RRMOV,
         CLS_ALU,
         CLS_PUSH,
         CLS_POP:   shape.has_reg = 1'b1;
         CLS_IRMOV,
         CLS_RMMOV,
         CLS_MRMOV: begin
            shape.has_reg   = 1'b1;
            shape.has_const = 1'b1;
         end
         CLS_JUMP,
         CLS_CALL:  shape.has_const = 1'b1;
         default:   shape.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/idec_const_asm.sv
module idec_const_asm #(
   parameter int CONST_BYTES = 4,
   parameter int LANE_W      = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clear,
   input  logic                     load,
   input  logic [LANE_W-1:0]        lane,
   input  logic [7:0]               din,
   output logic [CONST_BYTES*8-1:0] value
);

   for (genvar g = 0; g < CONST_BYTES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst || clear)
            value[g*8 +: 8] <= '0;
         else if (load && lane == LANE_W'(g))
            value[g*8 +: 8] <= din;
      end
   end

endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
   import idec_pkg::*;
#(
   parameter int CONST_BYTES = 4,
   parameter int LANE_W      = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              out_ready,
   input  idec_shape_t       head_shape,
   output idec_state_e       state,
   output logic              take,
   output logic [LANE_W-1:0] lane
);

   localparam logic [LANE_W-1:0] LANE_END = LANE_W'(CONST_BYTES - 1);

   logic need_const_q;

   assign take = in_valid && (state != ST_EMIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         state        <= ST_HEAD;
         lane         <= '0;
         need_const_q <= 1'b0;
      end else begin
         unique case (state)
            ST_HEAD: if (take) begin
               lane         <= '0;
               need_const_q <= head_shape.has_const;
               if (head_shape.bad || (!head_shape.has_reg && !head_shape.has_const))
                  state <= ST_EMIT;
               else if (head_shape.has_reg)
                  state <= ST_REGS;
               else
                  state <= ST_CONST;
            end
            ST_REGS: if (take)
               state <= need_const_q ? ST_CONST : ST_EMIT;
            ST_CONST: if (take) begin
               lane <= lane + 1'b1;
               if (lane == LANE_END)
                  state <= ST_EMIT;
            end
            ST_EMIT: if (out_ready)
               state <= ST_HEAD;
            default: state <= ST_HEAD;
         endcase
      end
   end

endmodule

// File: rtl/ibyte_decoder.sv
module ibyte_decoder
   import idec_pkg::*;
#(
   parameter int CONST_BYTES = 4,
   parameter int LANE_W      = $clog2(CONST_BYTES),
   parameter int LEN_W       = $clog2(CONST_BYTES + 3)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [7:0]               in_byte,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [3:0]               out_class,
   output logic [3:0]               out_func,
   output logic [3:0]               out_ra,
   output logic [3:0]               out_rb,
   output logic [CONST_BYTES*8-1:0] out_const,
   output logic [LEN_W-1:0]         out_len,
   output logic                     out_invalid,
   output logic                     out_halt
);

   if (CONST_BYTES < 2 || CONST_BYTES > 8) begin : g_bad_const
      $error("ibyte_decoder: CONST_BYTES must lie in 2..8");
   end
   if (LANE_W != $clog2(CONST_BYTES)) begin : g_bad_lane
      $error("ibyte_decoder: LANE_W must not be overridden");
   end
   if (LEN_W != $clog2(CONST_BYTES + 3)) begin : g_bad_len
      $error("ibyte_decoder: LEN_W must not be overridden");
   end

   idec_state_e       state;
   logic              take;
   logic [LANE_W-1:0] lane;
   idec_shape_t       head_shape;

   idec_class_table u_table (
      .cls   (in_byte[7:4]),
      .shape (head_shape)
   );

   idec_ctrl #(.CONST_BYTES(CONST_BYTES), .LANE_W(LANE_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .out_ready  (out_ready),
      .head_shape (head_shape),
      .state      (state),
      .take       (take),
      .lane       (lane)
   );

   wire take_head  = take && (state == ST_HEAD);
   wire take_regs  = take && (state == ST_REGS);
   wire take_const = take && (state == ST_CONST);

   idec_const_asm #(.CONST_BYTES(CONST_BYTES), .LANE_W(LANE_W)) u_const (
      .clk   (clk),
      .rst   (rst),
      .clear (take_head),
      .load  (take_const),
      .lane  (lane),
      .din   (in_byte),
      .value (out_const)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_class   <= '0;
         out_func    <= '0;
         out_ra      <= NO_REG;
         out_rb      <= NO_REG;
         out_len     <= '0;
         out_invalid <= 1'b0;
         out_halt    <= 1'b0;
      end else if (take_head) begin
         out_class   <= in_byte[7:4];
         out_func    <= in_byte[3:0];
         out_ra      <= NO_REG;
         out_rb      <= NO_REG;
         out_len     <= LEN_W'(1);
         out_invalid <= head_shape.bad;
         out_halt    <= head_shape.halt;
      end else if (take_regs) begin
         out_ra  <= in_byte[7:4];
         out_rb  <= in_byte[3:0];
         out_len <= out_len + 1'b1;
      end else if (take_const) begin
         out_len <= out_len + 1'b1;
      end
   end

   assign in_ready  = (state != ST_EMIT);
   assign out_valid = (state == ST_EMIT);

endmodule

// File: rtl/idec_checker.sv
module idec_checker #(
   parameter int CONST_BYTES = 4,
   parameter int LEN_W       = 3
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_ready,
   input logic                     out_valid,
   input logic                     out_ready,
   input logic [3:0]               out_class,
   input logic [3:0]               out_func,
   input logic [3:0]               out_ra,
   input logic [3:0]               out_rb,
   input logic [CONST_BYTES*8-1:0] out_const,
   input logic [LEN_W-1:0]         out_len,
   input logic                     out_invalid,
   input logic                     out_halt
);

   localparam logic [LEN_W-1:0] LEN_LONG = LEN_W'(CONST_BYTES + 2);
   localparam logic [LEN_W-1:0] LEN_JMP  = LEN_W'(CONST_BYTES + 1);

   logic [LEN_W-1:0] want_len;
   always_comb begin
      case (out_class)
         4'h2, 4'h6, 4'hA, 4'hB: want_len = LEN_W'(2);
         4'h3, 4'h4, 4'h5:       want_len = LEN_LONG;
         4'h7, 4'h8:             want_len = LEN_JMP;
         default:                want_len = LEN_W'(1);
      endcase
   end

   AST_LEN_BY_CLASS: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_len == want_len);  // R1

   AST_NOREG_SHORT: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_len == LEN_W'(1)) |-> (out_ra == 4'hF && out_rb == 4'hF && out_const == '0));  // R3

   AST_INVALID_SHORT: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_invalid) |-> (out_len == LEN_W'(1) && out_class > 4'hB));  // R5

   AST_HALT_CLASS: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_halt == (out_class == 4'h0)));  // R6

   AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !in_ready);  // R7

   AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_class) && $stable(out_func)
                                      && $stable(out_ra) && $stable(out_rb)
                                      && $stable(out_const) && $stable(out_len)));  // R7

   AST_RESET_EMPTY: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready));  // R8

endmodule

bind ibyte_decoder idec_checker #(.CONST_BYTES(CONST_BYTES), .LEN_W(LEN_W)) u_idec_chk (
   .clk         (clk),
   .rst         (rst),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_class   (out_class),
   .out_func    (out_func),
   .out_ra      (out_ra),
   .out_rb      (out_rb),
   .out_const   (out_const),
   .out_len     (out_len),
   .out_invalid (out_invalid),
   .out_halt    (out_halt)
);

// File: tb/tb_ibyte_decoder.sv
`timescale 1ns/1ps
module tb_ibyte_decoder;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        in_ready;
   logic [7:0]  in_byte;
   logic        out_valid;
   logic        out_ready;
   logic [3:0]  out_class, out_func, out_ra, out_rb;
   logic [31:0] out_const;
   logic [2:0]  out_len;
   logic        out_invalid, out_halt;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   logic [3:0]  r_class, r_func, r_ra, r_rb;
   logic [31:0] r_const;
   logic [2:0]  r_len;
   logic        r_invalid, r_halt;

   always #2 clk = ~clk;

   ibyte_decoder dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
      .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class), .out_func(out_func),
      .out_ra(out_ra), .out_rb(out_rb), .out_const(out_const), .out_len(out_len),
      .out_invalid(out_invalid), .out_halt(out_halt)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit has_reg(input logic [3:0] c);
      return (c >= 4'h2 && c <= 4'h6) || c == 4'hA || c == 4'hB;
   endfunction
   function automatic bit has_const(input logic [3:0] c);
      return (c >= 4'h3 && c <= 4'h5) || c == 4'h7 || c == 4'h8;
   endfunction
   function automatic logic [2:0] exp_len(input logic [3:0] c);
      if (c > 4'hB) return 3'd1;
      return 3'd1 + (has_reg(c) ? 3'd1 : 3'd0) + (has_const(c) ? 3'd4 : 3'd0);
   endfunction

   // called at a negedge, returns at the negedge after the byte was taken
   task automatic send_byte(input logic [7:0] b, input int gap);
      in_byte  = b;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic send_instr(input logic [3:0] c, input logic [3:0] f, input logic [7:0] regs,
                             input logic [31:0] k, input int gap);
      send_byte({c, f}, gap);
      if (c <= 4'hB && has_reg(c)) send_byte(regs, gap);
      if (c <= 4'hB && has_const(c))
         for (int i = 0; i < 4; i++) send_byte(k[i*8 +: 8], gap);
   endtask

   task automatic get_rec();
      out_ready = 1'b1;
      while (!out_valid) @(negedge clk);
      r_class = out_class; r_func = out_func; r_ra = out_ra; r_rb = out_rb;
      r_const = out_const; r_len = out_len; r_invalid = out_invalid; r_halt = out_halt;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic check_instr(input logic [3:0] c, input logic [3:0] f, input logic [7:0] regs,
                              input logic [31:0] k, input int gap);
      bit valid_c = (c <= 4'hB);
      send_instr(c, f, regs, k, gap);
      get_rec();
      chk("R2", "class", 32'(r_class), 32'(c));
      chk("R2", "func", 32'(r_func), 32'(f));
      chk("R3", "ra", 32'(r_ra), (valid_c && has_reg(c)) ? 32'(regs[7:4]) : 32'hF);
      chk("R3", "rb", 32'(r_rb), (valid_c && has_reg(c)) ? 32'(regs[3:0]) : 32'hF);
      chk("R4", "const", r_const, (valid_c && has_const(c)) ? k : 32'h0);
      chk("R1", "len", 32'(r_len), 32'(exp_len(c)));
      chk("R5", "invalid", 32'(r_invalid), 32'(!valid_c));
      chk("R6", "halt", 32'(r_halt), 32'(c == 4'h0));
   endtask

   task automatic t_reset();
      chk("R8", "out_valid after reset", 32'(out_valid), 32'h0);
      chk("R8", "in_ready after reset", 32'(in_ready), 32'h1);
   endtask

   task automatic t_all_classes();
      for (int c = 0; c < 12; c++)
         check_instr(4'(c), 4'(c + 3), 8'(8'h10 * ((c % 7) + 1) + (c % 5)), 32'hA1B2C300 + 32'(c), 0);
   endtask

   task automatic t_invalid();
      for (int c = 12; c < 16; c++) begin
         check_instr(4'(c), 4'h5, 8'h00, 32'h0, 0);
         check_instr(4'h1, 4'h0, 8'h00, 32'h0, 0);  // R5 next byte is a fresh head
      end
   endtask

   task automatic t_stream_boundary();
      // R9 constant bytes resemble halt and immediate-move opcodes
      check_instr(4'h7, 4'h3, 8'h00, 32'h10003000, 0);
      check_instr(4'h8, 4'h0, 8'h00, 32'h00B0A030, 0);
      check_instr(4'h9, 4'h0, 8'h00, 32'h0, 0);
      check_instr(4'h3, 4'h0, 8'hF2, 32'h00000000, 0);
   endtask

   task automatic t_gaps();
      check_instr(4'h5, 4'h0, 8'h31, 32'hDEADBEEF, 3);  // R7 idle cycles between bytes
      check_instr(4'h6, 4'h1, 8'h67, 32'h0, 2);
   endtask

   task automatic t_hold();
      logic [31:0] k0;
      send_instr(4'h3, 4'h0, 8'hF3, 32'h55667788, 0);
      in_byte  = 8'h30;
      in_valid = 1'b1;
      k0 = out_const;
      for (int i = 0; i < 3; i++) begin
         chk("R7", "in_ready while pending", 32'(in_ready), 32'h0);
         chk("R7", "record held", out_const, k0);
         @(negedge clk);
      end
      in_valid = 1'b0;
      get_rec();
      chk("R7", "held const", r_const, 32'h55667788);
      chk("R7", "held rb", 32'(r_rb), 32'h3);
      check_instr(4'h1, 4'h0, 8'h00, 32'h0, 0);  // R7 offered byte was not consumed
   endtask

   task automatic t_reset_mid();
      send_byte(8'h30, 0);
      send_byte(8'hF2, 0);
      send_byte(8'h11, 0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R8", "out_valid after mid reset", 32'(out_valid), 32'h0);
      chk("R8", "in_ready after mid reset", 32'(in_ready), 32'h1);
      check_instr(4'h0, 4'h0, 8'h00, 32'h0, 0);  // R8 partial instruction dropped
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_all_classes();
      t_invalid();
      t_stream_boundary();
      t_gaps();
      t_hold();
      t_reset_mid();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
         end
      end
   end

endmodule